// File: doc/BRIEF.md
# Flash Halfword Prefetch Buffer

This block connects a processor instruction-fetch port, which asks for 16-bit halfwords, to a slow flash array that returns 32 bits per read. The array needs a programmable number of wait-state cycles. The block keeps a single 32-bit word in a buffer, tagged with its word address. A fetch that misses the buffer starts an array read. When the read completes, the returned word is stored in the buffer and the requested halfword is sent back. A later fetch of the other halfword of that word is answered from the buffer in one cycle. Straight-line code therefore costs the full wait-state count, then one cycle, then the full count, then one cycle, and so on.

Each request is a single-cycle strobe on `req_valid`, with the halfword address on `req_addr`. The requester waits for the `rsp_ready` pulse before it sends the next strobe. It may send that strobe in the very cycle `rsp_ready` is high. The array read port is combinational: the array must present the word addressed by `arr_addr` on `arr_rdata` in any cycle where `arr_en` is high. The block samples that word in the last cycle of the access.

Top module: `flash_halfword_prefetch`

## Requirements
- R1: After reset, `rsp_ready` and `arr_en` are low and the buffer holds no valid word, so the first request is always a miss.
- R2: A miss completes after max(`wait_states`, 1) cycles. Cycles are counted from the clock edge that accepts the strobe, and that edge counts as the first. `rsp_ready` is high for exactly one cycle per request. This holds for both sequential and non-sequential addresses.
- R3: When `wait_states` is 2 or more, a request whose word address (`req_addr[ADDR_W-1:2]`) matches the valid buffered word is answered one cycle after acceptance, without an array access.
- R4: `req_addr` carries byte-address bits [ADDR_W-1:1]. Bit 1 picks the halfword: 0 returns `arr_rdata[15:0]` of the word, and 1 returns `arr_rdata[31:16]`.
- R5: Fetches to consecutive halfword addresses starting on a word boundary, with `wait_states` of 2 or more, take the full count, one cycle, the full count, one cycle, and so on.
- R6: When `wait_states` is 0 or 1, every request reads the array, even when it asks for the word read just before, and each request takes one cycle.
- R7: Any change of `wait_states` invalidates the buffer, so the next request is a miss.
- R8: During a miss, `arr_en` is high from the accepting cycle until the cycle of the final sample. `arr_addr` holds the requested word address throughout. A hit does not raise `arr_en`.
- R9: A strobe that arrives while a miss is in progress is ignored. The outstanding request still completes with its own data and its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_states | input | WS_W | Array wait-state count |
| req_valid | input | 1 | Single-cycle fetch strobe |
| req_addr | input | ADDR_W-1 | Halfword address (byte address bits [ADDR_W-1:1]) |
| rsp_ready | output | 1 | One-cycle pulse marking a returned halfword |
| rsp_data | output | 16 | Returned halfword |
| arr_en | output | 1 | Array read in progress |
| arr_addr | output | ADDR_W-2 | Array word address |
| arr_rdata | input | 32 | Array read data |

## Verification
The assertions check, on every cycle, the following behaviours:
- A hit is answered on the next cycle with the buffered halfword and never touches the array.
- A miss drives the requested word address.
- The array address stays steady while an access is outstanding.
- The end of every access produces a response.
- Unbuffered settings always go to the array.

Some behaviours can only be shown by the bench's scenarios. These are the exact miss latency for each wait-state setting, the alternating cost pattern on straight-line fetches, invalidation after a setting change, and the rejection of strobes during a miss. The bench's reference model follows the buffer tag and the wait-state setting, and it predicts the response cycle and data for each request.

// File: rtl/flash_halfword_prefetch.sv
module flash_halfword_prefetch #(
  parameter int ADDR_W     = 16,
  parameter int WS_W       = 4,
  parameter int BUF_MIN_WS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WS_W-1:0]   wait_states,
  input  logic              req_valid,
  input  logic [ADDR_W-1:1] req_addr,
  output logic              rsp_ready,
  output logic [15:0]       rsp_data,
  output logic              arr_en,
  output logic [ADDR_W-3:0] arr_addr,
  input  logic [31:0]       arr_rdata
);
  localparam int WA_W = ADDR_W - 2;

  logic [WS_W-1:0] ws_q, cnt;
  logic            busy, buf_vld, pend_hi;
  logic [WA_W-1:0] buf_wa, pend_wa;
  logic [31:0]     buf_data;

  wire [WA_W-1:0] req_wa   = req_addr[ADDR_W-1:2];
  wire            ws_chg   = wait_states != ws_q;
  wire            buffered = wait_states >= WS_W'(BUF_MIN_WS);
  wire            accept   = req_valid & ~busy;
  wire            hit      = buf_vld & ~ws_chg & buffered & (buf_wa == req_wa);
  wire [WS_W-1:0] miss_len = (wait_states == '0) ? WS_W'(1) : wait_states;
  wire            start    = accept & ~hit;
  wire            fill     = (start & (miss_len == WS_W'(1))) | (busy & (cnt == WS_W'(1)));
  wire            fill_hi  = busy ? pend_hi : req_addr[1];

  assign arr_en   = start | busy;
  assign arr_addr = busy ? pend_wa : req_wa;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q      <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      buf_vld   <= 1'b0;
      pend_hi   <= 1'b0;
      buf_wa    <= '0;
      pend_wa   <= '0;
      buf_data  <= '0;
      rsp_ready <= 1'b0;
      rsp_data  <= '0;
    end else begin
      ws_q      <= wait_states;
      rsp_ready <= 1'b0;
      if (accept && hit) begin
        rsp_ready <= 1'b1;
        rsp_data  <= req_addr[1] ? buf_data[31:16] : buf_data[15:0];
      end
      if (start && miss_len != WS_W'(1)) begin
        busy    <= 1'b1;
        cnt     <= miss_len - WS_W'(1);
        pend_wa <= req_wa;
        pend_hi <= req_addr[1];
      end
      if (busy) begin
        if (cnt == WS_W'(1)) busy <= 1'b0;
        else                 cnt  <= cnt - WS_W'(1);
      end
      if (fill) begin
        buf_data  <= arr_rdata;
        buf_wa    <= arr_addr;
        buf_vld   <= 1'b1;
        rsp_ready <= 1'b1;
        rsp_data  <= fill_hi ? arr_rdata[31:16] : arr_rdata[15:0];
      end
      if (ws_chg) buf_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_halfword_prefetch_chk.sv
module flash_halfword_prefetch_chk #(
  parameter int ADDR_W = 16,
  parameter int WS_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WS_W-1:0]   wait_states,
  input logic              req_valid,
  input logic [ADDR_W-1:1] req_addr,
  input logic              rsp_ready,
  input logic [15:0]       rsp_data,
  input logic              arr_en,
  input logic [ADDR_W-3:0] arr_addr,
  input logic              busy,
  input logic              hit,
  input logic [31:0]       buf_data
);
  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && hit) |=> rsp_ready &&
      rsp_data == ($past(req_addr[1]) ? $past(buf_data[31:16]) : $past(buf_data[15:0])));

  a_r8_hit_no_array: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && hit) |-> !arr_en);

  a_r8_miss_drives_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !hit) |-> arr_en && arr_addr == req_addr[ADDR_W-1:2]);

  a_r8_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr));

  a_r2_end_responds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_ready);

  a_r6_unbuffered_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && wait_states < WS_W'(2)) |-> arr_en);
endmodule

bind flash_halfword_prefetch flash_halfword_prefetch_chk #(.ADDR_W(ADDR_W), .WS_W(WS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_states(wait_states), .req_valid(req_valid),
  .req_addr(req_addr), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .arr_en(arr_en),
  .arr_addr(arr_addr), .busy(busy), .hit(hit), .buf_data(buf_data)
);

// File: tb/flash_halfword_prefetch_bench.sv
module flash_halfword_prefetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wait_states = 4'd3;
  logic        req_valid = 1'b0;
  logic [15:1] req_addr = '0;
  logic        rsp_ready, arr_en;
  logic [15:0] rsp_data;
  logic [13:0] arr_addr;
  logic [31:0] arr_rdata;

  int checks = 0, failures = 0;
  bit mv = 0;
  int mword = 0, mws = 3;

  always #2 clk = ~clk;

  function automatic logic [31:0] arr_fn(input logic [13:0] w);
    arr_fn = {2'b10, w, 16'(w * 16'd7) ^ 16'h1111};
  endfunction

  assign arr_rdata = arr_en ? arr_fn(arr_addr) : 32'h0BAD_0BAD;

  flash_halfword_prefetch u_flash_halfword_prefetch (
    .clk(clk), .rst_n(rst_n), .wait_states(wait_states), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .arr_en(arr_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ws(input int ws);
    if (ws != mws) mv = 0;  // R7 model: any setting change drops the buffer
    mws = ws;
    wait_states = 4'(ws);
  endtask

  task automatic do_req(input logic [15:0] a, input bit intrude, input string tag);
    logic [13:0] w = a[15:2];
    logic [31:0] word = arr_fn(w);
    logic [15:0] exp = a[1] ? word[31:16] : word[15:0];
    bit hit = mv && mws >= 2 && mword == int'(w);
    int len = hit ? 1 : (mws == 0 ? 1 : mws);
    req_valid = 1'b1;
    req_addr  = a[15:1];
    #1;
    chk(arr_en == !hit, {tag, " R8 arr_en at accept"}, arr_en, !hit);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 1; cyc <= len; cyc++) begin
      if (cyc < len) begin
        chk(rsp_ready == 1'b0, {tag, " R2 early response"}, rsp_ready, 0);
        chk(arr_en && arr_addr == w, {tag, " R8 array hold"}, arr_addr, w);
        if (intrude && cyc == 1) begin
          req_valid = 1'b1;  // R9 stray strobe during a miss
          req_addr  = a[15:1] ^ 15'h0080;
        end
        @(negedge clk);
        req_valid = 1'b0;
      end else begin
        chk(rsp_ready == 1'b1, {tag, hit ? " R3 hit latency" : " R2 miss latency"}, rsp_ready, 1);
        chk(rsp_data == exp, {tag, " R4 halfword data"}, rsp_data, exp);
      end
    end
    mv = 1;
    mword = int'(w);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_ready == 0, "R1 reset rsp_ready", rsp_ready, 0);
    chk(arr_en == 0, "R1 reset arr_en", arr_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 first fetch misses, R5 alternating 3,1,3,1
    for (int i = 0; i < 8; i++) do_req(16'(2 * i), 0, "R5 ws3 seq");
    set_ws(2);
    @(negedge clk);
    for (int i = 0; i < 6; i++) do_req(16'h0040 + 16'(2 * i), 0, "R5 ws2 seq");
    do_req(16'h0106, 0, "R4 upper half");
    do_req(16'h0104, 0, "R4 lower half");
    do_req(16'h0200, 0, "R2 jump");
    do_req(16'h1000, 0, "R2 jump far");
    do_req(16'h0202, 0, "R2 return miss");
    set_ws(0);
    do_req(16'h0300, 0, "R6 ws0");
    do_req(16'h0302, 0, "R6 ws0 same word");
    set_ws(1);
    @(negedge clk);
    do_req(16'h0300, 0, "R6 ws1");
    do_req(16'h0302, 0, "R6 ws1 same word");
    set_ws(3);
    do_req(16'h0400, 0, "R7 fill");
    do_req(16'h0402, 0, "R7 hit");
    set_ws(2);
    @(negedge clk);
    do_req(16'h0400, 0, "R7 after change");
    do_req(16'h0402, 0, "R7 refill hit");
    set_ws(7);
    do_req(16'h0500, 1, "R9 intrude");
    @(negedge clk);
    chk(rsp_ready == 0, "R9 no extra response", rsp_ready, 0);
    do_req(16'h0502, 0, "R9 hit after");
    set_ws(15);
    do_req(16'h7FFE, 1, "R2 ws15");
    do_req(16'h7FFC, 0, "R3 ws15 hit");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule